// File: doc/BRIEF.md
# Near Relative Jump Target Unit

This unit takes a window of instruction bytes together with the address of the instruction's first byte, and resolves a relative unconditional jump in 64-bit mode. It recognises an optional operand-size override (byte value 66h) in the first byte. It then classifies the opcode that follows as a short jump with an 8-bit displacement (EBh), a near jump with a wider displacement (E9h), or unsupported. From this it returns the instruction length, the new instruction pointer, a taken flag and an unsupported flag.

The target is the sign-extended displacement added to the address of the instruction that follows the jump. The override has two effects. It narrows the near form's displacement from 32 to 16 bits. It also makes the unit truncate the computed target to its low 16 bits and clear every upper bit. The result is registered, so a request presented with `in_valid` produces its answer on the next clock cycle.

Top module: `jrel_target_unit`

## Requirements
- R1: While reset is held and after it is released, with no request yet accepted, `out_valid`, `out_taken`, `out_unsup`, `out_len` and `out_target` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The other outputs change only after such a request, and otherwise they keep their values whatever the inputs do.
- R3: Without an override, when byte 0 is EBh the result has length 2, taken=1, unsup=0. The target is `in_pc + 2` plus byte 1 read as a signed 8-bit value, computed over the full 64 bits.
- R4: Without an override, when byte 0 is E9h the result has length 5. The displacement is bytes 1 to 4 read little-endian as a signed 32-bit value, and the target is `in_pc + 5 + disp` over the full 64 bits.
- R5: When byte 0 is 66h and byte 1 is E9h, the displacement is bytes 2 and 3 read little-endian as a signed 16-bit value and the length is 4. The target keeps only the low 16 bits of `in_pc + 4 + disp`, and bits 63:16 are zero.
- R6: When byte 0 is 66h and byte 1 is EBh, the displacement is byte 2 read as a signed 8-bit value and the length is 3. The target is truncated to 16 bits and zero-extended, as in R5.
- R7: When the opcode byte (byte 0, or byte 1 after a single 66h) is neither EBh nor E9h, the result has unsup=1, taken=0, length 0 and target 0. This includes a second 66h.
- R8: The 64-bit target addition wraps modulo 2^64.
- R9: Window bytes beyond the decoded instruction do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one per decoded window |
| in_pc | input | 64 | Address of the window's first byte |
| in_win | input | 64 | Instruction bytes, byte 0 in bits 7:0 |
| out_valid | output | 1 | Result present, one cycle after the request |
| out_len | output | 4 | Decoded instruction length in bytes |
| out_target | output | 64 | New instruction pointer |
| out_taken | output | 1 | A supported jump was decoded |
| out_unsup | output | 1 | Opcode byte not supported |

## Verification
The bench builds the unit with its default parameters: a 64-bit address, an 8-byte window and a 16-bit narrow width. With a full 64-bit address, a program counter placed near the top of the space shows the wrap of R8. Carries and borrows across bit 16 show that the narrow truncation discards them. The 8-byte window leaves three spare bytes after the longest instruction, and filling them with random values exercises R9. Random windows with random filler on idle cycles check both the decode and the holding of results between requests.

// File: rtl/jrel_pkg.sv
package jrel_pkg;
  typedef enum logic [1:0] {
    JK_NONE  = 2'd0,
    JK_SHORT = 2'd1,
    JK_NEAR  = 2'd2
  } jump_kind_e;

  typedef enum logic [1:0] {
    DW_8  = 2'd0,
    DW_16 = 2'd1,
    DW_32 = 2'd2
  } disp_width_e;
endpackage

// File: rtl/jrel_prefix_decode.sv
module jrel_prefix_decode
  import jrel_pkg::*;
#(
  parameter int          LEN_W    = 4,
  parameter logic [7:0]  PFX_BYTE = 8'h66,
  parameter logic [7:0]  SHORT_OP = 8'hEB,
  parameter logic [7:0]  NEAR_OP  = 8'hE9
) (
  input  logic [15:0]      head_i,
  output jump_kind_e       kind_o,
  output logic             narrow_o,
  output logic [LEN_W-1:0] disp_pos_o,
  output disp_width_e      disp_w_o,
  output logic [LEN_W-1:0] len_o
);
  logic [7:0]       first_byte;
  logic [7:0]       second_byte;
  logic             has_pfx;
  logic [7:0]       opc;
  logic [LEN_W-1:0] pfx_len;

  assign first_byte  = head_i[7:0];
  assign second_byte = head_i[15:8];
  assign has_pfx     = (first_byte == PFX_BYTE);
  assign opc         = has_pfx ? second_byte : first_byte;
  assign pfx_len     = has_pfx ? LEN_W'(1) : LEN_W'(0);
  assign narrow_o    = has_pfx;
  assign disp_pos_o  = pfx_len + LEN_W'(1);

  always_comb begin
    kind_o   = JK_NONE;
    disp_w_o = DW_8;
    len_o    = '0;
    if (opc == SHORT_OP) begin
      kind_o   = JK_SHORT;
      disp_w_o = DW_8;
      len_o    = pfx_len + LEN_W'(2);
    end else if (opc == NEAR_OP) begin
      kind_o   = JK_NEAR;
      disp_w_o = has_pfx ? DW_16 : DW_32;
      len_o    = has_pfx ? LEN_W'(4) : LEN_W'(5);
    end
  end
endmodule

// File: rtl/jrel_disp_extract.sv
module jrel_disp_extract
  import jrel_pkg::*;
#(
  parameter int WIN_BYTES = 8,
  parameter int ADDR_W    = 64,
  parameter int LEN_W     = 4
) (
  input  logic [WIN_BYTES*8-1:0] win_i,
  input  logic [LEN_W-1:0]       pos_i,
  input  disp_width_e            width_i,
  output logic [ADDR_W-1:0]      disp_o
);
  localparam int NUM_WIDTHS = 3;

  logic [WIN_BYTES*8-1:0] shifted;
  logic [31:0]            aligned;
  logic [ADDR_W-1:0]      cand [NUM_WIDTHS];

  assign shifted = win_i >> {pos_i, 3'b000};
  assign aligned = shifted[31:0];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int DW = 8 << g;
    assign cand[g] = {{(ADDR_W-DW){aligned[DW-1]}}, aligned[DW-1:0]};
  end

  always_comb begin
    case (width_i)
      DW_16:   disp_o = cand[1];
      DW_32:   disp_o = cand[2];
      default: disp_o = cand[0];
    endcase
  end
endmodule

// File: rtl/jrel_target_calc.sv
module jrel_target_calc #(
  parameter int ADDR_W   = 64,
  parameter int LEN_W    = 4,
  parameter int NARROW_W = 16
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic              narrow_i,
  output logic [ADDR_W-1:0] target_o
);
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] sum;

  assign next_pc  = pc_i + {{(ADDR_W-LEN_W){1'b0}}, len_i};
  assign sum      = next_pc + disp_i;
  assign target_o = narrow_i ? {{(ADDR_W-NARROW_W){1'b0}}, sum[NARROW_W-1:0]} : sum;
endmodule

// File: rtl/jrel_target_unit.sv
module jrel_target_unit
  import jrel_pkg::*;
#(
  parameter int         ADDR_W    = 64,
  parameter int         WIN_BYTES = 8,
  parameter int         NARROW_W  = 16,
  parameter logic [7:0] PFX_BYTE  = 8'h66,
  parameter logic [7:0] SHORT_OP  = 8'hEB,
  parameter logic [7:0] NEAR_OP   = 8'hE9
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic [ADDR_W-1:0]                  in_pc,
  input  logic [WIN_BYTES*8-1:0]             in_win,
  output logic                               out_valid,
  output logic [$clog2(WIN_BYTES+1)-1:0]     out_len,
  output logic [ADDR_W-1:0]                  out_target,
  output logic                               out_taken,
  output logic                               out_unsup
);
  localparam int LEN_W = $clog2(WIN_BYTES+1);

  jump_kind_e        kind;
  logic              narrow;
  logic [LEN_W-1:0]  disp_pos;
  disp_width_e       disp_w;
  logic [LEN_W-1:0]  dec_len;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] calc_target;

  logic              valid_d;
  logic [LEN_W-1:0]  len_d;
  logic [ADDR_W-1:0] target_d;
  logic              taken_d;
  logic              unsup_d;

  jrel_prefix_decode #(
    .LEN_W(LEN_W), .PFX_BYTE(PFX_BYTE), .SHORT_OP(SHORT_OP), .NEAR_OP(NEAR_OP)
  ) u_dec (
    .head_i(in_win[15:0]), .kind_o(kind), .narrow_o(narrow),
    .disp_pos_o(disp_pos), .disp_w_o(disp_w), .len_o(dec_len)
  );

  jrel_disp_extract #(
    .WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_disp (
    .win_i(in_win), .pos_i(disp_pos), .width_i(disp_w), .disp_o(disp)
  );

  jrel_target_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NARROW_W(NARROW_W)
  ) u_calc (
    .pc_i(in_pc), .len_i(dec_len), .disp_i(disp), .narrow_i(narrow),
    .target_o(calc_target)
  );

  always_comb begin
    valid_d  = in_valid;
    taken_d  = (kind != JK_NONE);
    unsup_d  = (kind == JK_NONE);
    len_d    = taken_d ? dec_len : '0;
    target_d = taken_d ? calc_target : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_len    <= '0;
      out_target <= '0;
      out_taken  <= 1'b0;
      out_unsup  <= 1'b0;
    end else if (in_valid) begin
      out_len    <= len_d;
      out_target <= target_d;
      out_taken  <= taken_d;
      out_unsup  <= unsup_d;
    end
  end
endmodule

// File: rtl/jrel_target_unit_chk.sv
module jrel_target_unit_chk #(
  parameter int         ADDR_W    = 64,
  parameter int         WIN_BYTES = 8,
  parameter int         NARROW_W  = 16,
  parameter logic [7:0] PFX_BYTE  = 8'h66,
  parameter logic [7:0] SHORT_OP  = 8'hEB,
  parameter logic [7:0] NEAR_OP   = 8'hE9
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic [7:0]                     win_lo,
  input logic                           out_valid,
  input logic [$clog2(WIN_BYTES+1)-1:0] out_len,
  input logic [ADDR_W-1:0]              out_target,
  input logic                           out_taken,
  input logic                           out_unsup
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_target) && $stable(out_len) && $stable(out_taken)));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_taken != out_unsup));

  a_r7_unsup_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unsup) |-> (out_len == '0 && out_target == '0));

  a_r3_short_len: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && win_lo == SHORT_OP) |=> (out_len == 2));

  a_r4_near_len: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && win_lo == NEAR_OP) |=> (out_len == 5));

  a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && win_lo == PFX_BYTE) |=> (out_target[ADDR_W-1:NARROW_W] == '0));
endmodule

bind jrel_target_unit jrel_target_unit_chk #(
  .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .NARROW_W(NARROW_W),
  .PFX_BYTE(PFX_BYTE), .SHORT_OP(SHORT_OP), .NEAR_OP(NEAR_OP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .win_lo(in_win[7:0]),
  .out_valid(out_valid), .out_len(out_len), .out_target(out_target),
  .out_taken(out_taken), .out_unsup(out_unsup)
);

// File: tb/jrel_target_unit_tb.sv
`timescale 1ns/1ps
module jrel_target_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_pc;
  logic [63:0] in_win;
  logic        out_valid;
  logic [3:0]  out_len;
  logic [63:0] out_target;
  logic        out_taken;
  logic        out_unsup;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    cmp_en   = 0;
  bit    started  = 0;
  bit    done     = 0;
  string cur_tag  = "";

  logic        exp_valid;
  int          exp_len;
  logic [63:0] exp_target;
  logic        exp_taken;
  logic        exp_unsup;
  string       exp_tag;

  jrel_target_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_win(in_win),
    .out_valid(out_valid), .out_len(out_len), .out_target(out_target),
    .out_taken(out_taken), .out_unsup(out_unsup)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic [63:0] sx8(input logic [7:0] v);
    return {{56{v[7]}}, v};
  endfunction

  // Behavioural reference derived from R3..R7
  task automatic ref_eval(input logic [63:0] pc, input logic [63:0] w,
                          output int len, output logic [63:0] tgt,
                          output logic tk, output logic us, output string tag);
    logic [7:0]  b [8];
    logic [63:0] d;
    int          p;
    bit          pfx;
    for (int i = 0; i < 8; i++) b[i] = w[8*i +: 8];
    pfx = (b[0] == 8'h66);
    p   = pfx ? 1 : 0;
    tk = 1; us = 0; d = 0; len = 0;
    if (b[p] == 8'hEB) begin
      d = sx8(b[p+1]); len = p + 2; tag = pfx ? "R6" : "R3";
    end else if (b[p] == 8'hE9 && !pfx) begin
      d = {{32{b[4][7]}}, b[4], b[3], b[2], b[1]}; len = 5; tag = "R4";
    end else if (b[p] == 8'hE9) begin
      d = {{48{b[3][7]}}, b[3], b[2]}; len = 4; tag = "R5";
    end else begin
      tk = 0; us = 1; tag = "R7";
    end
    if (tk) begin
      tgt = pc + 64'(len) + d;
      if (pfx) tgt = tgt & 64'h0000_0000_0000_FFFF;
    end else begin
      tgt = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid  <= 0; exp_len <= 0; exp_target <= 0;
      exp_taken  <= 0; exp_unsup <= 0; exp_tag <= "R1";
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        int l; logic [63:0] t; logic k, u; string g;
        ref_eval(in_pc, in_win, l, t, k, u, g);
        exp_len <= l; exp_target <= t; exp_taken <= k; exp_unsup <= u;
        exp_tag <= (cur_tag != "") ? cur_tag : g;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      string tg;
      tg = exp_valid ? exp_tag : (started ? "R2" : "R1");
      n_checks++;
      if (out_valid !== exp_valid || out_len !== 4'(exp_len) || out_target !== exp_target ||
          out_taken !== exp_taken || out_unsup !== exp_unsup) begin
        n_fails++;
        $display("FAIL %s: got v=%0b len=%0d tgt=%h tk=%0b us=%0b exp v=%0b len=%0d tgt=%h tk=%0b us=%0b",
                 tg, out_valid, out_len, out_target, out_taken, out_unsup,
                 exp_valid, exp_len, exp_target, exp_taken, exp_unsup);
      end
    end
  end

  task automatic send(input logic [63:0] pc, input logic [63:0] w, input string tag);
    @(negedge clk);
    started  = 1;
    in_valid = 1; in_pc = pc; in_win = w; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_pc = {$urandom, $urandom}; in_win = {$urandom, $urandom};
    end
  endtask

  initial begin
    in_valid = 0; in_pc = 0; in_win = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n  = 1;
    cmp_en = 1;
    repeat (2) @(negedge clk);   // R1: reset state compared here
    send(64'h1000, {48'hDEAD_BEEF_CAFE, 8'h10, 8'hEB}, "R3");
    idle(2);
    send(64'h2000, {48'h0, 8'h80, 8'hEB}, "R3");
    send(64'h4000_0000, {24'hFFFFFF, 32'h1234_5678, 8'hE9}, "R4");
    send(64'h4000_0000, {24'h0, 32'h8000_0000, 8'hE9}, "R4");
    idle(1);
    send(64'hFFFF_FFFF_0000_FFF0, {32'hAAAA_AAAA, 16'h0020, 8'hE9, 8'h66}, "R5");
    send(64'h1234_5678_9ABC_0005, {40'h55_5555_5555, 8'hF0, 8'hEB, 8'h66}, "R6");
    send(64'h10, {56'h0, 8'h90}, "R7");
    send(64'h10, {40'h0, 8'hE9, 8'h66, 8'h66}, "R7");
    send(64'hFFFF_FFFF_FFFF_FFF0, {24'h0, 32'h0000_0100, 8'hE9}, "R8");
    send(64'hFFFF_FFFF_FFFF_FFFE, {48'h0, 8'h7F, 8'hEB}, "R8");
    send(64'h1000, {48'h1234_5678_9ABC, 8'h10, 8'hEB}, "R9");
    send(64'h3000, {24'h777777, 32'h0000_0040, 8'hE9}, "R9");
    idle(3);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] w;
      int sel;
      w   = {$urandom, $urandom};
      sel = $urandom_range(0, 5);
      case (sel)
        0: w[7:0] = 8'hEB;
        1: w[7:0] = 8'hE9;
        2: begin w[7:0] = 8'h66; w[15:8] = 8'hEB; end
        3: begin w[7:0] = 8'h66; w[15:8] = 8'hE9; end
        default: ;
      endcase
      send({$urandom, $urandom}, w, "");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fails++;
      $display("FAIL R2: watchdog expired, got no completion, expected end of run");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule